// File: doc/BRIEF.md
# Asynchronous SRAM Write Timing Monitor

This block watches the write side of an asynchronous static RAM port. A fast reference clock samples the byte-enable lines, the write strobe, the address bus and the data bus. The block then measures enable-terminated write cycles in whole clock periods. A write counts only while at least one byte enable and the write strobe are both low in the same sample. The write ends at the sample where every byte enable has returned high. At that point the block compares four intervals against minimums set by parameters:

- the length of the enable-low pulse;
- the time since the address last changed;
- the time since the data bus last changed;
- the spacing between the two address changes on either side of the write.

Each kind of breach sets its own flag. A flag stays set until a synchronous clear is sampled. A 16-bit counter records every write that ends this way.

The monitor sits beside a memory controller, either in simulation or on the chip for debug. All inputs pass through one register stage. The results of the sample taken at clock edge n show at the outputs just after edge n+1.

Top module: `sram_wr_timing_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four flags and `wr_count` are zero after that edge.
- R2: An end of write is a sample in which all bits of `be_n` are 1, where the previous sample had at least one `be_n` bit at 0 and `we_n` at 0. Each end of write adds one to the 16-bit `wr_count`, which wraps from 65535 to 0. This happens whether or not a flag is set. A sample taken at edge n is reflected at the outputs after edge n+1.
- R3: At an end of write, `flg_pulse` is set if fewer than `MIN_PULSE` consecutive samples before it had an enable low.
- R4: At an end of write, `flg_addr` is set if the distance in samples from the last address change to the end-of-write sample is below `MIN_ADDR`. A change is a sample that differs from the one before it.
- R5: At an end of write, `flg_data` is set if the distance in samples from the last data change to the end-of-write sample is below `MIN_DATA`.
- R6: On an address change, `flg_cycle` is set if an end of write occurred since the previous address change, or in the same sample, and the two changes are fewer than `MIN_CYCLE` samples apart.
- R7: If `we_n` rises before the enables do, or the enables go low while `we_n` is high, the count does not change and no flag is set.
- R8: A sample with `clr` high clears all four flags and leaves `wr_count` as it is. If a flag is set by the same sample, that flag ends up set.
- R9: Once set, a flag stays set until a `clr` sample.
- R10: The interval counters saturate at 2^`AGE_W`-1. After a long quiet period, a write whose address and data were set up long before it raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous flag clear, sampled with the bus |
| addr | input | ADDR_W | Monitored address bus |
| be_n | input | NBE | Monitored byte enables, active low |
| we_n | input | 1 | Monitored write strobe, active low |
| data | input | DATA_W | Monitored write data bus |
| flg_pulse | output | 1 | Sticky enable-pulse-too-short flag |
| flg_addr | output | 1 | Sticky address-window flag |
| flg_data | output | 1 | Sticky data-setup flag |
| flg_cycle | output | 1 | Sticky write-cycle-time flag |
| wr_count | output | 16 | Completed write count, wrapping |

## Verification
A wrong internal state shows up at the ports at the first end of write that depends on it. A bad interval age, pulse counter or bracket marker turns into a wrong flag. A bad end-of-write decision turns into a wrong count. Either appears just after the edge that follows the faulty sample. Because the outputs are compared against a behavioural model on every cycle, a fault is reported within two clock edges of the stimulus that exposes it. Long idle spans, coincident clear and set, and W-first release are driven on purpose so that errors in saturation and in the early-release rule cannot stay hidden.

// File: rtl/mon_pkg.sv
// Shared definitions for the SRAM write timing monitor.
// Assumes: all users import this package before declaring ports.
package mon_pkg;
    localparam int CNT_W = 16;

    // One bit per timing rule; order fixed so all modules agree.
    typedef struct packed {
        logic cyc;
        logic dat;
        logic adr;
        logic pls;
    } viol_t;
endpackage

// File: rtl/mon_sampler.sv
// Two-stage sampling register with change detection.
// Holds the current sample and the one before it, and flags a difference.
// Assumes: the input is already in the clk domain or is only observed.
module mon_sampler #(
    parameter int               W   = 8,
    parameter logic [W-1:0]     RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv,
    output logic         chg
);
    // Capture the bus and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= RST;
            prv <= RST;
        end else begin
            cur <= din;
            prv <= cur;
        end
    end

    // A change means the two stored samples differ.
    assign chg = (cur != prv);
endmodule

// File: rtl/mon_age.sv
// Saturating age counter: number of samples since the last restart.
// Assumes: after reset it starts at its maximum, so nothing is "recent".
module mon_age #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] age
);
    localparam logic [CW-1:0] AGE_MAX = '1;

    // Restart to zero on an event, otherwise count up and hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= AGE_MAX;
        else if (restart)
            age <= '0;
        else if (age != AGE_MAX)
            age <= age + 1'b1;
    end

    // Once saturated with no restart, the age must stay saturated.
    assert_age_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == AGE_MAX && !restart) |=> (age == AGE_MAX));
endmodule

// File: rtl/mon_enable.sv
// Enable-pulse tracker: counts consecutive enable-low samples and
// detects the end of a write (enables released while W was low).
// Assumes: be_s/be_p/we_p come from mon_sampler stages.
module mon_enable #(
    parameter int NBE = 4,
    parameter int CW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NBE-1:0] be_s,
    input  logic [NBE-1:0] be_p,
    input  logic           we_p,
    output logic           eow,
    output logic [CW-1:0]  low_cnt
);
    localparam logic [CW-1:0] LOW_MAX = '1;

    logic en_low_s;
    logic en_low_p;

    assign en_low_s = ~&be_s;
    assign en_low_p = ~&be_p;

    // End of write: enables were low together with W, and now all are high.
    assign eow = en_low_p & ~we_p & ~en_low_s;

    // Length of the current enable-low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (!en_low_s)
            low_cnt <= '0;
        else if (low_cnt != LOW_MAX)
            low_cnt <= low_cnt + 1'b1;
    end

    // Two ends of write can never be back to back.
    assert_eow_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eow |=> !eow);
endmodule

// File: rtl/sram_wr_timing_mon.sv
// SRAM write timing monitor (top).
// Samples an asynchronous SRAM write port on clk, measures enable-ended
// writes in clock samples and sets sticky flags for timing breaches.
// Assumes: thresholds are in samples, each at least 1 and below 2^AGE_W-1.
module sram_wr_timing_mon
    import mon_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NBE       = 4,
    parameter int AGE_W     = 8,
    parameter int MIN_PULSE = 10,
    parameter int MIN_ADDR  = 12,
    parameter int MIN_DATA  = 7,
    parameter int MIN_CYCLE = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBE-1:0]    be_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] data,
    output logic              flg_pulse,
    output logic              flg_addr,
    output logic              flg_data,
    output logic              flg_cycle,
    output logic [CNT_W-1:0]  wr_count
);
    localparam logic [AGE_W:0] TH_PULSE = (AGE_W+1)'(MIN_PULSE);
    localparam logic [AGE_W:0] TH_ADDR  = (AGE_W+1)'(MIN_ADDR);
    localparam logic [AGE_W:0] TH_DATA  = (AGE_W+1)'(MIN_DATA);
    localparam logic [AGE_W:0] TH_CYC   = (AGE_W+1)'(MIN_CYCLE);

    logic [ADDR_W-1:0] addr_s, addr_p;
    logic [DATA_W-1:0] data_s, data_p;
    logic [NBE-1:0]    be_s, be_p;
    logic [0:0]        we_s, we_p, clr_s, clr_p;
    logic              addr_chg, data_chg, be_chg, we_chg, clr_chg;
    logic [AGE_W-1:0]  age_a, age_d, low_cnt;
    logic              eow, wsince;
    logic [AGE_W:0]    dist_a, dist_d;
    viol_t             setv, flags;

    // Input sampling stages for each monitored signal.
    mon_sampler #(.W(ADDR_W), .RST('0)) u_s_addr (
        .clk(clk), .rst_n(rst_n), .din(addr), .cur(addr_s), .prv(addr_p), .chg(addr_chg));
    mon_sampler #(.W(DATA_W), .RST('0)) u_s_data (
        .clk(clk), .rst_n(rst_n), .din(data), .cur(data_s), .prv(data_p), .chg(data_chg));
    mon_sampler #(.W(NBE), .RST('1)) u_s_be (
        .clk(clk), .rst_n(rst_n), .din(be_n), .cur(be_s), .prv(be_p), .chg(be_chg));
    mon_sampler #(.W(1), .RST(1'b1)) u_s_we (
        .clk(clk), .rst_n(rst_n), .din(we_n), .cur(we_s), .prv(we_p), .chg(we_chg));
    mon_sampler #(.W(1), .RST(1'b0)) u_s_clr (
        .clk(clk), .rst_n(rst_n), .din(clr), .cur(clr_s), .prv(clr_p), .chg(clr_chg));

    // Ages since the last address change and the last data change.
    mon_age #(.CW(AGE_W)) u_age_a (
        .clk(clk), .rst_n(rst_n), .restart(addr_chg), .age(age_a));
    mon_age #(.CW(AGE_W)) u_age_d (
        .clk(clk), .rst_n(rst_n), .restart(data_chg), .age(age_d));

    // Enable-low run length and end-of-write detection.
    mon_enable #(.NBE(NBE), .CW(AGE_W)) u_en (
        .clk(clk), .rst_n(rst_n), .be_s(be_s), .be_p(be_p), .we_p(we_p[0]),
        .eow(eow), .low_cnt(low_cnt));

    // Distance from the last change to the current sample.
    assign dist_a = {1'b0, age_a} + 1'b1;
    assign dist_d = {1'b0, age_d} + 1'b1;

    // Rule evaluation for the current sample.
    always_comb begin
        setv.pls = eow && ({1'b0, low_cnt} < TH_PULSE);
        setv.adr = eow && (dist_a < TH_ADDR);
        setv.dat = eow && (dist_d < TH_DATA);
        setv.cyc = addr_chg && (wsince || eow) && (dist_a < TH_CYC);
    end

    // Remember whether a write ended since the last address change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wsince <= 1'b0;
        else if (addr_chg)
            wsince <= 1'b0;
        else if (eow)
            wsince <= 1'b1;
    end

    // Sticky flags: clear on a clr sample, a set in the same sample wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~{4{clr_s[0]}}) | setv;
    end

    // Completed-write counter, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_count <= '0;
        else if (eow)
            wr_count <= wr_count + 1'b1;
    end

    assign flg_pulse = flags.pls;
    assign flg_addr  = flags.adr;
    assign flg_data  = flags.dat;
    assign flg_cycle = flags.cyc;

    // The counter moves by at most one per cycle.
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_count == $past(wr_count)) || (wr_count == $past(wr_count) + 1'b1));
    // A pulse flag can only rise after an end of write.
    assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg_pulse) |-> $past(eow));
    // The cycle flag can only rise after an address change.
    assert_cycle_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg_cycle) |-> $past(addr_chg));
    // A clear with nothing to set leaves the address flag low.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s[0] && !setv.adr) |=> !flg_addr);
    // Without a clear, a set data flag stays set.
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_data && !clr_s[0]) |=> flg_data);
endmodule

// File: tb/sim_sram_wr_timing_mon.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module sim_sram_wr_timing_mon;
    localparam int MP = 10, MA = 12, MD = 7, MC = 15, AMAX = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] addr = '0;
    logic [3:0]  be_n = 4'hF;
    logic        we_n = 1'b1;
    logic [31:0] data = '0;
    logic        flg_pulse, flg_addr, flg_data, flg_cycle;
    logic [15:0] wr_count;

    int total = 0;
    int bad = 0;

    // Drive values applied on the next tick.
    logic        d_clr = 1'b0;
    logic [15:0] d_addr = '0;
    logic [3:0]  d_be = 4'hF;
    logic        d_we = 1'b1;
    logic [31:0] d_data = '0;

    // Model state.
    logic [15:0] m_pa;
    logic [31:0] m_pd;
    logic [3:0]  m_pbe;
    logic        m_pwe;
    int          m_age_a, m_age_d, m_low;
    bit          m_ws;
    logic [3:0]  m_f;
    logic [15:0] m_cnt;

    typedef struct {
        logic [3:0]  f;
        logic [15:0] c;
    } exp_t;
    exp_t q[$];

    sram_wr_timing_mon u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .addr(addr), .be_n(be_n),
        .we_n(we_n), .data(data), .flg_pulse(flg_pulse), .flg_addr(flg_addr),
        .flg_data(flg_data), .flg_cycle(flg_cycle), .wr_count(wr_count));

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: process one sample and queue the expected outputs.
    task automatic mstep();
        bit ac, eow, enl, penl;
        logic [3:0] s;
        exp_t e;
        ac   = (d_addr != m_pa);
        enl  = (d_be != 4'hF);
        penl = (m_pbe != 4'hF);
        eow  = penl && !m_pwe && !enl;
        s = '0;
        if (eow) begin
            m_cnt = m_cnt + 16'd1;
            s[0] = (m_low < MP);
            s[1] = (m_age_a + 1 < MA);
            s[2] = (m_age_d + 1 < MD);
        end
        s[3] = ac && (m_ws || eow) && (m_age_a + 1 < MC);
        if (ac) m_ws = 0; else if (eow) m_ws = 1;
        m_f = (d_clr ? 4'h0 : m_f) | s;
        m_age_a = ac ? 0 : (m_age_a < AMAX ? m_age_a + 1 : AMAX);
        m_age_d = (d_data != m_pd) ? 0 : (m_age_d < AMAX ? m_age_d + 1 : AMAX);
        m_low = enl ? (m_low < AMAX ? m_low + 1 : AMAX) : 0;
        m_pa = d_addr; m_pd = d_data; m_pbe = d_be; m_pwe = d_we;
        e.f = m_f; e.c = m_cnt;
        q.push_back(e);
    endtask

    // One cycle: compare against the expectation, then drive and model.
    task automatic tick();
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        chk(flg_pulse == e.f[0], "R3 flg_pulse", flg_pulse, e.f[0]);
        chk(flg_addr  == e.f[1], "R4 flg_addr",  flg_addr,  e.f[1]);
        chk(flg_data  == e.f[2], "R5 flg_data",  flg_data,  e.f[2]);
        chk(flg_cycle == e.f[3], "R6 flg_cycle", flg_cycle, e.f[3]);
        chk(wr_count  == e.c,    "R2 wr_count",  wr_count,  e.c);
        clr = d_clr; addr = d_addr; be_n = d_be; we_n = d_we; data = d_data;
        mstep();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Enable-ended write: address lead, data setup before the end, pulse length.
    task automatic wr(input logic [15:0] a, input logic [31:0] dv, input int lead,
                      input int dsu, input int pulse, input int tail);
        d_addr = a;
        run(lead);
        d_be = 4'b1010; d_we = 1'b0;
        for (int i = 0; i < pulse; i++) begin
            if (i == ((pulse > dsu) ? pulse - dsu : 0)) d_data = dv;
            tick();
        end
        d_be = 4'hF; d_we = 1'b1;
        run(tail);
    endtask

    initial begin
        logic [15:0] c0;
        m_pa = '0; m_pd = '0; m_pbe = 4'hF; m_pwe = 1'b1;
        m_age_a = AMAX; m_age_d = AMAX; m_low = 0; m_ws = 0; m_f = '0; m_cnt = '0;
        repeat (4) @(negedge clk);
        chk({flg_pulse, flg_addr, flg_data, flg_cycle} == 4'b0, "R1 flags", 0, 0);
        chk(wr_count == 16'd0, "R1 count", wr_count, 0);
        rst_n = 1'b1;
        q.push_back('{f: 4'h0, c: 16'h0});
        mstep();

        // Long idle, then a compliant write (R10, R2).
        run(300);
        wr(16'h0011, 32'hA5A5_0001, 5, 7, 10, 10);
        run(3);
        chk({flg_pulse, flg_addr, flg_data, flg_cycle} == 4'b0, "R10 no flag", 0, 0);
        chk(wr_count == 16'd1, "R2 count one", wr_count, 1);

        // Short enable pulse (R3).
        wr(16'h0022, 32'h1, 5, 7, 9, 10);
        run(2);
        chk(flg_pulse == 1'b1, "R3 short pulse", flg_pulse, 1);

        // Clear (R8), then late address (R4).
        d_clr = 1'b1; tick(); d_clr = 1'b0; run(2);
        chk({flg_pulse, flg_addr, flg_data, flg_cycle} == 4'b0, "R8 cleared", 0, 0);
        chk(wr_count == 16'd2, "R8 count kept", wr_count, 2);
        wr(16'h0033, 32'h2, 1, 7, 10, 10);
        run(2);
        chk(flg_addr == 1'b1, "R4 late addr", flg_addr, 1);

        // Late data (R5), flags stay set over idle (R9).
        wr(16'h0044, 32'h3, 5, 6, 10, 10);
        run(20);
        chk(flg_data == 1'b1, "R5 late data", flg_data, 1);
        chk(flg_addr == 1'b1, "R9 sticky", flg_addr, 1);

        // Short write cycle between bracketing address changes (R6).
        d_clr = 1'b1; tick(); d_clr = 1'b0;
        wr(16'h0055, 32'h4, 2, 7, 10, 0);
        d_addr = 16'h0066; run(20);
        chk(flg_cycle == 1'b1, "R6 short cycle", flg_cycle, 1);

        // W released first, and enables low with W high (R7).
        d_clr = 1'b1; tick(); d_clr = 1'b0;
        c0 = wr_count;
        d_be = 4'b0000; d_we = 1'b0; run(3);
        d_we = 1'b1; tick();
        d_be = 4'hF; run(3);
        d_be = 4'b0111; run(4);
        d_be = 4'hF; run(4);
        chk(wr_count == c0, "R7 no count", wr_count, c0);
        chk({flg_pulse, flg_addr, flg_data, flg_cycle} == 4'b0, "R7 no flag", 0, 0);

        // Clear and short pulse in the same sample: set wins (R8).
        d_be = 4'b1110; d_we = 1'b0; run(3);
        d_be = 4'hF; d_we = 1'b1; d_clr = 1'b1; tick(); d_clr = 1'b0;
        run(2);
        chk(flg_pulse == 1'b1, "R8 set wins", flg_pulse, 1);

        // Counter wrap with minimal writes (R2).
        c0 = wr_count;
        for (int i = 0; i < 65536; i++) begin
            d_be = 4'b0000; d_we = 1'b0; tick();
            d_be = 4'hF; d_we = 1'b1; tick();
        end
        run(3);
        chk(wr_count == c0, "R2 wrap", wr_count, c0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1900000;
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule